// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block is the front end that turns 24 external interrupt lines into requests for a main interrupt controller. Lines 0 to 7 come from an 8-pin port (port A) and lines 8 to 23 from a 16-pin port (port B), where pin j of port B is line j+8. A line takes part only while its pin's 2-bit function select is `10`. Every cycle the block registers each pin and compares that sample with the sample before it. A rising or falling change counts as an event when the line's 3-bit trigger code accepts that direction.

Lines 0 to 3 have no mask and no pending storage. Each one pulses its own request output. Lines 4 to 23 can be masked, and an unmasked event sets a sticky pending bit. Lines 4 to 7 feed one shared request and lines 8 to 23 feed a second one. Software reaches the trigger codes, the mask and the pending bits over a simple write/read register port. A pending bit is cleared by writing a one to it.

Top module: `eint_ctrl`

## Requirements
- R1: A line whose 2-bit function select is anything other than `10` never produces an event: its pin changes do not pulse a request and do not set a pending bit.
- R2: A low-to-high change of a sampled pin is an event when the line's trigger code is 1, 4, 5, 6 or 7.
- R3: A high-to-low change of a sampled pin is an event when the line's trigger code is 0, 2, 3, 6 or 7.
- R4: Trigger codes are stored in three registers at offsets 0x88, 0x8C and 0x90. Line l uses the register at 0x88 + 4*(l/8), bits [4*(l mod 8)+2 : 4*(l mod 8)]. Bit 3 of every 4-bit field reads 0. All three registers reset to 0. Port A pin i is line i and port B pin j is line j+8.
- R5: The mask register at 0xA4 resets to 0x00FFFFF0. A write keeps only bits 4 to 23, and the other bits read 0. Mask bit l = 1 masks line l.
- R6: An event on a masked line does not set its pending bit, and clearing the mask later does not make the event appear.
- R7: The pending register at 0xA8 resets to 0. Bit l (4 to 23) is set by an unmasked event on line l, and bits 0 to 3 and 24 to 31 read 0. Register reads are combinational on `rd_addr`.
- R8: Writing 0xA8 clears each pending bit written as 1 and leaves the bits written as 0 unchanged. If an event sets a bit in the same cycle as a write that clears it, the bit ends up set.
- R9: Timing: a pin value present at clock edge k is sampled at k. The event caused by that value updates the pending bits and the line 0 to 3 request pulses at edge k+1. `irq_solo[i]` is high for exactly the cycle after each event on line i (i = 0 to 3).
- R10: `irq_grp_a` is high exactly while some bit 4 to 7 is both pending and unmasked. `irq_grp_b` is the same for bits 8 to 23.
- R11: Writes to any other offset change no register, and reads of any other offset return 0.
- R12: Masking a line that is already pending keeps the pending bit but removes its contribution to the shared request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_a | input | 8 | Pin values of port A (lines 0 to 7) |
| cfg_a | input | 16 | 2-bit function select per port A pin |
| pins_b | input | 16 | Pin values of port B (lines 8 to 23) |
| cfg_b | input | 32 | 2-bit function select per port B pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data |
| irq_solo | output | 4 | Per-event pulses for lines 0 to 3 |
| irq_grp_a | output | 1 | Shared request for lines 4 to 7 |
| irq_grp_b | output | 1 | Shared request for lines 8 to 23 |

## Verification
The bench checks the asymmetric code sets by sweeping every trigger code through both edge directions. A design that used a mirrored set for falling edges would flag codes 1, 4 or 5 on a fall, or miss code 0 on a fall.

It also checks these cases:
- **Clear and set in the same cycle.** A design where the clear wins would drop the new event.
- **Events while masked, then unmasked.** A design that stores masked events would raise stale pending bits.
- **Masking after a bit is pending.** A design that gates only the setting of a bit would keep the shared request high.
- **Port B lines.** Trigger changes are driven on these lines to catch a mode register picked with the wrong offset.
- **Unconfigured pins and unmapped offsets.** These must have no effect.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int OFS_MODE_BASE = 'h88;
  localparam int OFS_MASK      = 'hA4;
  localparam int OFS_PEND      = 'hA8;
  localparam int MODE_STRIDE   = 4;
  localparam int FIELD_W       = 4;
  localparam int CODE_W        = 3;
  localparam logic [1:0] CFG_EINT = 2'b10;

  typedef logic [CODE_W-1:0] trig_code_t;

  // Codes 1 and 4..7 accept a rising change (4..7 all carry bit 2).
  function automatic logic fires_on_rise(trig_code_t c);
    return (c == 3'd1) || c[2];
  endfunction

  // Codes 1, 4 and 5 reject a falling change; every other code accepts it.
  function automatic logic fires_on_fall(trig_code_t c);
    return !((c == 3'd1) || (c == 3'd4) || (c == 3'd5));
  endfunction

  function automatic logic line_event(logic now, logic was, logic en, trig_code_t c);
    logic rise, fall;
    rise = now && !was;
    fall = !now && was;
    return en && ((rise && fires_on_rise(c)) || (fall && fires_on_fall(c)));
  endfunction

endpackage

// File: rtl/eint_line_detect.sv
module eint_line_detect
  import eint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] cfg,
  input  trig_code_t mode,
  output logic       evt,
  output logic       samp,
  output logic       hist
);

  logic samp_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      samp_q <= pin;
      hist_q <= samp_q;
    end
  end

  assign evt  = line_event(samp_q, hist_q, cfg == CFG_EINT, mode);
  assign samp = samp_q;
  assign hist = hist_q;

  // An event always comes from a change between the two samples (R2, R3).
  assert_evt_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (samp_q != hist_q));

endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int NUM_SOLO  = 4,
  parameter int AW        = 8,
  parameter int DW        = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [DW-1:0]                     wr_data,
  input  logic [AW-1:0]                     rd_addr,
  output logic [DW-1:0]                     rd_data,
  input  logic [NUM_LINES-1:0]              evt_v,
  output logic [NUM_LINES-1:0][CODE_W-1:0]  mode_v,
  output logic [NUM_LINES-1:0]              mask_v,
  output logic [NUM_LINES-1:0]              pend_v
);

  localparam int FIELDS = DW / FIELD_W;
  localparam logic [NUM_LINES-1:0] MASK_VALID =
    {{(NUM_LINES-NUM_SOLO){1'b1}}, {NUM_SOLO{1'b0}}};

  logic [NUM_LINES-1:0][CODE_W-1:0] mode_q;
  logic [NUM_LINES-1:0] mask_q, pend_q, pend_nxt, clr_v;
  logic wr_mask, wr_pend;

  assign wr_mask = wr_en && (wr_addr == AW'(OFS_MASK));
  assign wr_pend = wr_en && (wr_addr == AW'(OFS_PEND));
  assign clr_v   = wr_pend ? wr_data[NUM_LINES-1:0] : '0;
  // Set wins over a clear in the same cycle.
  assign pend_nxt = ((pend_q & ~clr_v) | (evt_v & ~mask_q)) & MASK_VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= MASK_VALID;
      pend_q <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (wr_mask) mask_q <= wr_data[NUM_LINES-1:0] & MASK_VALID;
      if (wr_en) begin
        for (int l = 0; l < NUM_LINES; l++) begin
          if (wr_addr == AW'(OFS_MODE_BASE + MODE_STRIDE * (l / FIELDS)))
            mode_q[l] <= wr_data[FIELD_W*(l % FIELDS) +: CODE_W];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (rd_addr == AW'(OFS_MODE_BASE + MODE_STRIDE * (l / FIELDS)))
        rd_data[FIELD_W*(l % FIELDS) +: CODE_W] = mode_q[l];
    end
    if (rd_addr == AW'(OFS_MASK)) rd_data[NUM_LINES-1:0] = mask_q;
    if (rd_addr == AW'(OFS_PEND)) rd_data[NUM_LINES-1:0] = pend_q;
  end

  assign mode_v = mode_q;
  assign mask_v = mask_q;
  assign pend_v = pend_q;

  // A bit that was masked and clear cannot become pending one cycle later (R6).
  assert_masked_stays_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(mask_q & ~pend_q)) == '0);

  // A written one clears its bit unless an event arrived in that same cycle (R8).
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(wr_data[NUM_LINES-1:0] & ~evt_v)) == '0));

endmodule

// File: rtl/eint_route.sv
module eint_route #(
  parameter int NUM_LINES = 24,
  parameter int NUM_SOLO  = 4,
  parameter int LINES_A   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] evt_v,
  input  logic [NUM_LINES-1:0] mask_v,
  input  logic [NUM_LINES-1:0] pend_v,
  output logic [NUM_SOLO-1:0]  irq_solo,
  output logic                 irq_grp_a,
  output logic                 irq_grp_b
);

  logic [NUM_SOLO-1:0] solo_q;
  logic [NUM_LINES-1:0] live_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) solo_q <= '0;
    else        solo_q <= evt_v[NUM_SOLO-1:0];
  end

  assign live_v    = pend_v & ~mask_v;
  assign irq_solo  = solo_q;
  assign irq_grp_a = |live_v[LINES_A-1:NUM_SOLO];
  assign irq_grp_b = |live_v[NUM_LINES-1:LINES_A];

  // A shared request needs stored pending state behind it (R10).
  assert_grp_a_has_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_a |-> (pend_v[LINES_A-1:NUM_SOLO] != '0));
  assert_grp_b_has_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_b |-> (pend_v[NUM_LINES-1:LINES_A] != '0));

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int LINES_A  = 8,
  parameter int LINES_B  = 16,
  parameter int NUM_SOLO = 4,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES_A-1:0]   pins_a,
  input  logic [2*LINES_A-1:0] cfg_a,
  input  logic [LINES_B-1:0]   pins_b,
  input  logic [2*LINES_B-1:0] cfg_b,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NUM_SOLO-1:0]  irq_solo,
  output logic                 irq_grp_a,
  output logic                 irq_grp_b
);

  localparam int NUM_LINES = LINES_A + LINES_B;

  logic [NUM_LINES-1:0] pin_v, en_v, evt_v, samp_v, hist_v, chg_v;
  logic [NUM_LINES-1:0] mask_v, pend_v;
  logic [NUM_LINES-1:0][1:0] cfg_v;
  logic [NUM_LINES-1:0][CODE_W-1:0] mode_v;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    if (l < LINES_A) begin : g_port_a
      assign pin_v[l] = pins_a[l];
      assign cfg_v[l] = cfg_a[2*l +: 2];
    end else begin : g_port_b
      assign pin_v[l] = pins_b[l-LINES_A];
      assign cfg_v[l] = cfg_b[2*(l-LINES_A) +: 2];
    end
    assign en_v[l] = (cfg_v[l] == CFG_EINT);

    eint_line_detect u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_v[l]),
      .cfg  (cfg_v[l]),
      .mode (mode_v[l]),
      .evt  (evt_v[l]),
      .samp (samp_v[l]),
      .hist (hist_v[l])
    );
  end

  assign chg_v = samp_v ^ hist_v;

  eint_regs #(
    .NUM_LINES(NUM_LINES), .NUM_SOLO(NUM_SOLO), .AW(AW), .DW(DW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .evt_v  (evt_v),
    .mode_v (mode_v),
    .mask_v (mask_v),
    .pend_v (pend_v)
  );

  eint_route #(
    .NUM_LINES(NUM_LINES), .NUM_SOLO(NUM_SOLO), .LINES_A(LINES_A)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_v    (evt_v),
    .mask_v   (mask_v),
    .pend_v   (pend_v),
    .irq_solo (irq_solo),
    .irq_grp_a(irq_grp_a),
    .irq_grp_b(irq_grp_b)
  );

  // A solo pulse needs an enabled line whose samples differed one cycle earlier (R1, R9).
  assert_solo_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_solo & ~$past(chg_v[NUM_SOLO-1:0] & en_v[NUM_SOLO-1:0])) == '0);

endmodule

// File: tb/eint_ctrl_bench.sv
module eint_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_a = '0;
  logic [15:0] cfg_a = '0;
  logic [15:0] pins_b = '0;
  logic [31:0] cfg_b = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq_solo;
  logic        irq_grp_a, irq_grp_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Behavioural model state
  bit [23:0] m_samp, m_hist, m_pend, m_mask;
  bit [3:0]  m_solo;
  int        m_mode [24];

  always #(CLK_PERIOD/2) clk = ~clk;

  eint_ctrl u_eint_ctrl (
    .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .cfg_a(cfg_a),
    .pins_b(pins_b), .cfg_b(cfg_b), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_solo(irq_solo), .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit fires(int l);
    int sel, md;
    bit now, was;
    now = m_samp[l];
    was = m_hist[l];
    sel = (l < 8) ? int'(cfg_a[2*l +: 2]) : int'(cfg_b[2*(l-8) +: 2]);
    md  = m_mode[l];
    if (sel != 2) return 0;
    if (now && !was) begin
      case (md)
        1, 4, 5, 6, 7: return 1;
        default:       return 0;
      endcase
    end
    if (!now && was) begin
      case (md)
        1, 4, 5: return 0;
        default: return 1;
      endcase
    end
    return 0;
  endfunction

  function automatic bit [31:0] model_read(bit [7:0] a);
    bit [31:0] v = 0;
    if (a == 8'h88 || a == 8'h8C || a == 8'h90) begin
      int base = (a - 8'h88) / 4 * 8;
      for (int f = 0; f < 8; f++) v[4*f +: 3] = 3'(m_mode[base + f]);
    end else if (a == 8'hA4) v = {8'h0, m_mask};
    else if (a == 8'hA8) v = {8'h0, m_pend};
    return v;
  endfunction

  task automatic cycle();
    bit [23:0] f, clr, n_pend, n_mask;
    for (int l = 0; l < 24; l++) f[l] = fires(l);
    clr    = (wr_en && wr_addr == 8'hA8) ? wr_data[23:0] : 24'h0;
    n_pend = ((m_pend & ~clr) | (f & ~m_mask)) & 24'hFFFFF0;
    n_mask = (wr_en && wr_addr == 8'hA4) ? (wr_data[23:0] & 24'hFFFFF0) : m_mask;
    if (wr_en && (wr_addr == 8'h88 || wr_addr == 8'h8C || wr_addr == 8'h90)) begin
      int base = (wr_addr - 8'h88) / 4 * 8;
      for (int k = 0; k < 8; k++) m_mode[base + k] = int'(wr_data[4*k +: 3]);
    end
    @(posedge clk);
    #1;
    m_solo = f[3:0];
    m_pend = n_pend;
    m_mask = n_mask;
    m_hist = m_samp;
    m_samp = {pins_b, pins_a};
    check("R9 solo", {28'h0, irq_solo}, {28'h0, m_solo});
    check("R10 grp_a", {31'h0, irq_grp_a}, {31'h0, |(m_pend[7:4] & ~m_mask[7:4])});
    check("R10 grp_b", {31'h0, irq_grp_b}, {31'h0, |(m_pend[23:8] & ~m_mask[23:8])});
    check("R7 rd_data", rd_data, model_read(rd_addr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd_lit(bit [7:0] a, bit [31:0] exp, string tag);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_samp = 0; m_hist = 0; m_pend = 0; m_mask = 24'hFFFFF0; m_solo = 0;
    for (int l = 0; l < 24; l++) m_mode[l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    rd_lit(8'h88, 32'h0, "R4 mode0 reset");
    rd_lit(8'h8C, 32'h0, "R4 mode1 reset");
    rd_lit(8'h90, 32'h0, "R4 mode2 reset");
    rd_lit(8'hA4, 32'h00FFFFF0, "R5 mask reset");
    rd_lit(8'hA8, 32'h0, "R7 pend reset");
    check("R9 solo reset", {28'h0, irq_solo}, 32'h0);

    // Mask write width
    wr(8'hA4, 32'hFFFFFFFF);
    rd_lit(8'hA4, 32'h00FFFFF0, "R5 mask bits");
    wr(8'hA4, 32'h0);
    rd_lit(8'hA4, 32'h0, "R5 mask clear");

    // Mode registers
    wr(8'h88, 32'h76543210);
    rd_lit(8'h88, 32'h76543210, "R4 mode0");
    wr(8'h8C, 32'hFFFFFFFF);
    rd_lit(8'h8C, 32'h77777777, "R4 mode1 bit3");
    wr(8'h8C, 32'h00000001);
    wr(8'h90, 32'h40000000);

    cfg_a = 16'hAAAA; cfg_b = 32'hAAAAAAAA;
    idle(2);

    // Rising sweep over codes 0..7 on lines 0..7
    pins_a = 8'hFF;
    cycle(); cycle();
    check("R9 solo rise", {28'h0, irq_solo}, 32'h2);
    check("R10 grp_a set", {31'h0, irq_grp_a}, 32'h1);
    cycle();
    check("R9 solo one cycle", {28'h0, irq_solo}, 32'h0);
    rd_lit(8'hA8, 32'h000000F0, "R2 rise codes");

    wr(8'hA8, 32'h30);
    rd_lit(8'hA8, 32'h000000C0, "R8 zeros keep");
    wr(8'hA8, 32'hFFFFFFFF);
    rd_lit(8'hA8, 32'h0, "R8 clear all");
    check("R10 grp_a clear", {31'h0, irq_grp_a}, 32'h0);

    // Falling sweep
    pins_a = 8'h00;
    cycle(); cycle();
    check("R3 solo fall", {28'h0, irq_solo}, 32'hD);
    cycle();
    rd_lit(8'hA8, 32'h000000C0, "R3 fall codes");
    wr(8'hA8, 32'hFFFFFFFF);

    // Unconfigured pins
    cfg_a = 16'h5555;
    pins_a = 8'hFF; idle(3);
    pins_a = 8'h00; idle(3);
    rd_lit(8'hA8, 32'h0, "R1 not configured");
    cfg_a = 16'hAAAA;
    idle(2);

    // Port B mapping: line 8 code 1, line 23 code 4, line 15 code 0
    pins_b = 16'h0001;
    cycle(); cycle();
    check("R10 grp_b set", {31'h0, irq_grp_b}, 32'h1);
    rd_lit(8'hA8, 32'h00000100, "R4 line8");
    pins_b = 16'h8081;
    idle(3);
    rd_lit(8'hA8, 32'h00800100, "R4 line23");

    // Mask after pending
    wr(8'hA4, 32'h00800100);
    check("R12 grp_b masked", {31'h0, irq_grp_b}, 32'h0);
    rd_lit(8'hA8, 32'h00800100, "R12 pend kept");
    wr(8'hA4, 32'h0);
    check("R12 grp_b back", {31'h0, irq_grp_b}, 32'h1);
    wr(8'hA8, 32'hFFFFFFFF);

    // Masked event (line 9, code 0 falls)
    wr(8'hA4, 32'h00000200);
    pins_b = 16'h8083; idle(3);
    pins_b = 16'h8081; idle(3);
    rd_lit(8'hA8, 32'h0, "R6 masked");
    wr(8'hA4, 32'h0);
    idle(2);
    rd_lit(8'hA8, 32'h0, "R6 no late set");

    // Set wins over clear on line 7 (code 7)
    pins_a = 8'h80;
    cycle();
    wr(8'hA8, 32'h00000080);
    rd_lit(8'hA8, 32'h00000080, "R8 set wins");

    // Unmapped offsets
    wr(8'h80, 32'hFFFFFFFF);
    wr(8'h94, 32'hFFFFFFFF);
    rd_lit(8'h80, 32'h0, "R11 read unmapped");
    rd_lit(8'hA8, 32'h00000080, "R11 pend intact");
    rd_lit(8'hA4, 32'h0, "R11 mask intact");
    rd_lit(8'h88, 32'h76543210, "R11 mode intact");

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] addrs [6] = '{8'h88, 8'h8C, 8'h90, 8'hA4, 8'hA8, 8'h80};
      if ($urandom_range(0, 2) == 0) pins_a = 8'($urandom);
      if ($urandom_range(0, 2) == 0) pins_b = 16'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        cfg_a = 16'hAAAA ^ 16'($urandom & $urandom);
        cfg_b = 32'hAAAAAAAA ^ ($urandom & $urandom);
      end
      rd_addr = addrs[$urandom_range(0, 5)];
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_addr = addrs[$urandom_range(0, 5)];
        wr_data = $urandom;
      end else wr_en = 1'b0;
      cycle();
    end
    wr_en = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule